// File: doc/BRIEF.md
# Full-Flag Cascade with Page-Address Loading

This block models a string of small associative storage slices joined by a full-flag chain. Each slice passes a chain signal to the next one. The signal is asserted when the slice and every slice above it are full. A next-free operation writes the comparand into the lowest empty entry of the whole string, and only the first non-full slice takes that write. The chain output of the last slice serves as the full flag for the whole string.

The same chain steers page-address loading during start-up. A page-address write lands in the slice that currently responds. A set-full command then forces that slice to report full while it is still empty, so the next page-address write goes to the following slice. A control reset afterwards empties every slice and drops the forced flags, and the loaded page addresses stay as they are. Software then writes the device-select value, normally 16'hFFFF, which is stored in every slice.

Commands arrive on one port as a valid strobe, a 3-bit opcode and a data word. Each command takes effect at the next rising clock edge. A read port gives a view of any entry without waiting for a clock.

Top module: `ffc_cascade`

## Requirements
- R1: After the hardware reset (rst_n low), every entry is invalid, no slice is forced full, every page-address and device-select register is zero, and slice_full_o and full_o are zero.
- R2: Opcode 1 (move next-free) writes cmd_data into the lowest-index empty entry of the responding slice and marks that entry valid. The change is visible on the read port after the next rising edge.
- R3: At most one slice responds at a time. The responding slice is the lowest-index slice that is not full. Next-free, set-full and page-address commands change no other slice.
- R4: slice_full_o[i] is 1 exactly when slice i and all slices below index i are full. A slice counts as full when it is forced full or all of its entries are valid. full_o equals slice_full_o[N-1].
- R5: Opcode 2 (set full) marks the responding slice forced full even when it holds no valid entry. The following slice then responds.
- R6: Opcode 3 (page-address write) loads cmd_data into the page-address register of the responding slice only.
- R7: Opcode 5 (control reset) clears every valid bit, every forced-full flag and every device-select register. All page-address registers are left unchanged.
- R8: Opcode 4 (device-select write) loads cmd_data into the device-select register of every slice.
- R9: Opcodes 1, 2 and 3 issued while full_o is 1 change no state.
- R10: A command with cmd_valid low changes no state. Opcodes 0, 6 and 7 also change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode: 0 none, 1 move next-free, 2 set full, 3 page-address write, 4 device-select write, 5 control reset |
| cmd_data | input | 16 | Comparand or register data |
| rd_slice | input | 2 | Slice selected for reading |
| rd_addr | input | 3 | Entry selected for reading |
| rd_valid | output | 1 | Valid bit of the selected entry |
| rd_data | output | 16 | Data of the selected entry |
| slice_full_o | output | 4 | Chain output of each slice |
| full_o | output | 1 | Full flag of the whole string |
| pa_flat | output | 64 | Page-address registers, slice i at bits [16*i+15:16*i] |
| ds_flat | output | 64 | Device-select registers, slice i at bits [16*i+15:16*i] |

## Verification
The assertions assume cmd_op is a known value whenever cmd_valid is high, and that the data word fits the register it targets. The stimulus meets both conditions. It always drives a defined opcode and data, and it changes inputs only on the falling edge. Control resets are kept rare in the random mix, so that the string reaches full often enough to test the ignore rule on a full string. The forced-full path is also reached through directed set-full runs.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_MOVE_NF = 3'd1,
        OP_SETFULL = 3'd2,
        OP_PA_WR   = 3'd3,
        OP_DS_WR   = 3'd4,
        OP_CRESET  = 3'd5
    } ffc_op_e;

    typedef struct packed {
        logic move_nf;
        logic set_full;
        logic pa_wr;
        logic ds_wr;
        logic creset;
    } ffc_strobe_t;
endpackage

// File: rtl/ffc_cmd_decode.sv
module ffc_cmd_decode
    import ffc_pkg::*;
(
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    output ffc_strobe_t strobe
);
    ffc_op_e op;

    always_comb begin
        op     = ffc_op_e'(cmd_op);
        strobe = '0;
        if (cmd_valid) begin
            case (op)
                OP_MOVE_NF: strobe.move_nf  = 1'b1;
                OP_SETFULL: strobe.set_full = 1'b1;
                OP_PA_WR:   strobe.pa_wr    = 1'b1;
                OP_DS_WR:   strobe.ds_wr    = 1'b1;
                OP_CRESET:  strobe.creset   = 1'b1;
                default:    strobe          = '0;
            endcase
        end
    end
endmodule

// File: rtl/ffc_first_free.sv
module ffc_first_free #(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] occupied,
    output logic             any_free,
    output logic [AW-1:0]    idx
);
    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (!occupied[k]) begin
                any_free = 1'b1;
                idx      = AW'(k);
            end
        end
    end
endmodule

// File: rtl/ffc_slice.sv
module ffc_slice
    import ffc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 16,
    parameter int PW    = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chain_in,
    input  ffc_strobe_t   strobe,
    input  logic [CW-1:0] data,
    input  logic [AW-1:0] rd_addr,
    output logic          chain_out,
    output logic          respond,
    output logic [PW-1:0] pa_o,
    output logic [PW-1:0] ds_o,
    output logic          rd_valid,
    output logic [CW-1:0] rd_data
);
    typedef struct packed {
        logic [DEPTH-1:0]         valid;
        logic [DEPTH-1:0][CW-1:0] mem;
        logic [PW-1:0]            pa;
        logic [PW-1:0]            ds;
        logic                     forced;
    } slice_st_t;

    slice_st_t     st_d, st_q;
    logic          own_full;
    logic          any_free;
    logic [AW-1:0] free_idx;

    ffc_first_free #(.DEPTH(DEPTH)) i_free (
        .occupied (st_q.valid),
        .any_free (any_free),
        .idx      (free_idx)
    );

    assign own_full  = st_q.forced | ~any_free;
    assign respond   = chain_in & ~own_full;
    assign chain_out = chain_in & own_full;
    assign pa_o      = st_q.pa;
    assign ds_o      = st_q.ds;
    assign rd_valid  = st_q.valid[rd_addr];
    assign rd_data   = st_q.mem[rd_addr];

    always_comb begin
        st_d = st_q;
        if (strobe.creset) begin
            st_d.valid  = '0;
            st_d.forced = 1'b0;
            st_d.ds     = '0;
        end else if (strobe.ds_wr) begin
            st_d.ds = data[PW-1:0];
        end else if (respond) begin
            if (strobe.move_nf) begin
                st_d.mem[free_idx]   = data;
                st_d.valid[free_idx] = 1'b1;
            end
            if (strobe.set_full) begin
                st_d.forced = 1'b1;
            end
            if (strobe.pa_wr) begin
                st_d.pa = data[PW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ffc_cascade.sv
module ffc_cascade
    import ffc_pkg::*;
#(
    parameter int N     = 4,
    parameter int DEPTH = 8,
    parameter int CW    = 16,
    parameter int PW    = 16,
    localparam int SW = (N > 1) ? $clog2(N) : 1,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [CW-1:0]   cmd_data,
    input  logic [SW-1:0]   rd_slice,
    input  logic [AW-1:0]   rd_addr,
    output logic            rd_valid,
    output logic [CW-1:0]   rd_data,
    output logic [N-1:0]    slice_full_o,
    output logic            full_o,
    output logic [N*PW-1:0] pa_flat,
    output logic [N*PW-1:0] ds_flat
);
    ffc_strobe_t   strobe;
    logic [N:0]    chain;
    logic [N-1:0]  resp;
    logic [N-1:0]  rv;
    logic [CW-1:0] rdat [N];

    ffc_cmd_decode i_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .strobe    (strobe)
    );

    assign chain[0] = 1'b1;

    for (genvar s = 0; s < N; s++) begin : g_slice
        ffc_slice #(.DEPTH(DEPTH), .CW(CW), .PW(PW)) i_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .chain_in  (chain[s]),
            .strobe    (strobe),
            .data      (cmd_data),
            .rd_addr   (rd_addr),
            .chain_out (chain[s+1]),
            .respond   (resp[s]),
            .pa_o      (pa_flat[s*PW +: PW]),
            .ds_o      (ds_flat[s*PW +: PW]),
            .rd_valid  (rv[s]),
            .rd_data   (rdat[s])
        );
    end

    assign slice_full_o = chain[N:1];
    assign full_o       = chain[N];

    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        for (int s = 0; s < N; s++) begin
            if (rd_slice == SW'(s)) begin
                rd_valid = rv[s];
                rd_data  = rdat[s];
            end
        end
    end
endmodule

// File: rtl/ffc_cascade_chk.sv
module ffc_cascade_chk #(
    parameter int N  = 4,
    parameter int CW = 16,
    parameter int PW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [2:0]      cmd_op,
    input logic [CW-1:0]   cmd_data,
    input logic [N-1:0]    slice_full_o,
    input logic            full_o,
    input logic [N*PW-1:0] pa_flat,
    input logic [N*PW-1:0] ds_flat,
    input logic [N-1:0]    resp
);
    // R3
    resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(resp));

    // R4
    full_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o == slice_full_o[N-1]);

    if (N > 1) begin : g_mono
        // R4
        chain_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (slice_full_o[N-1:1] & ~slice_full_o[N-2:0]) == '0);
    end

    // R7
    creset_keep_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd5) |=> (slice_full_o == '0 && pa_flat == $past(pa_flat) && ds_flat == '0));

    // R8
    ds_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4) |=> (ds_flat == {N{$past(cmd_data[PW-1:0])}}));

    // R9
    full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2 || cmd_op == 3'd3) && full_o)
        |=> ($stable(pa_flat) && full_o));

    // R5
    setfull_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2 && !full_o)
        |=> ($countones(slice_full_o) > $past($countones(slice_full_o))));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid) |=> ($stable(pa_flat) && $stable(ds_flat) && $stable(slice_full_o)));
endmodule

bind ffc_cascade ffc_cascade_chk #(.N(N), .CW(CW), .PW(PW)) i_ffc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_data     (cmd_data),
    .slice_full_o (slice_full_o),
    .full_o       (full_o),
    .pa_flat      (pa_flat),
    .ds_flat      (ds_flat),
    .resp         (resp)
);

// File: tb/test_ffc_cascade.sv
module test_ffc_cascade;
    localparam int N = 4;
    localparam int DEPTH = 8;
    localparam int CW = 16;
    localparam int PW = 16;
    localparam int SW = 2;
    localparam int AW = 3;
    localparam time CLK_PERIOD = 10ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_op = '0;
    logic [CW-1:0]   cmd_data = '0;
    logic [SW-1:0]   rd_slice = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic            rd_valid;
    logic [CW-1:0]   rd_data;
    logic [N-1:0]    slice_full_o;
    logic            full_o;
    logic [N*PW-1:0] pa_flat;
    logic [N*PW-1:0] ds_flat;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic          m_valid [N][DEPTH];
    logic [CW-1:0] m_mem   [N][DEPTH];
    logic [PW-1:0] m_pa    [N];
    logic [PW-1:0] m_ds    [N];
    logic          m_forced[N];

    ffc_cascade #(.N(N), .DEPTH(DEPTH), .CW(CW), .PW(PW)) i_ffc_cascade (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit own_full(input int s);
        bit all = 1'b1;
        for (int e = 0; e < DEPTH; e++) all &= m_valid[s][e];
        return m_forced[s] | all;
    endfunction

    function automatic logic [N-1:0] exp_full();
        logic [N-1:0] v;
        bit up = 1'b1;
        for (int s = 0; s < N; s++) begin
            up &= own_full(s);
            v[s] = up;
        end
        return v;
    endfunction

    function automatic int responder();
        bit up = 1'b1;
        for (int s = 0; s < N; s++) begin
            if (up && !own_full(s)) return s;
            up &= own_full(s);
        end
        return -1;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < N; s++) begin
            for (int e = 0; e < DEPTH; e++) begin
                m_valid[s][e] = 1'b0;
                m_mem[s][e] = '0;
            end
            m_pa[s] = '0;
            m_ds[s] = '0;
            m_forced[s] = 1'b0;
        end
    endtask

    task automatic model_apply(input logic v, input logic [2:0] op, input logic [CW-1:0] d);
        int r;
        if (!v) return;
        r = responder();
        case (op)
            3'd5: for (int s = 0; s < N; s++) begin
                for (int e = 0; e < DEPTH; e++) m_valid[s][e] = 1'b0;
                m_forced[s] = 1'b0;
                m_ds[s] = '0;
            end
            3'd4: for (int s = 0; s < N; s++) m_ds[s] = d[PW-1:0];
            3'd1: if (r >= 0) begin
                for (int e = 0; e < DEPTH; e++) begin
                    if (!m_valid[r][e]) begin
                        m_valid[r][e] = 1'b1;
                        m_mem[r][e] = d;
                        break;
                    end
                end
            end
            3'd2: if (r >= 0) m_forced[r] = 1'b1;
            3'd3: if (r >= 0) m_pa[r] = d[PW-1:0];
            default: ;
        endcase
    endtask

    task automatic compare_all(input string req);
        logic [N-1:0] ef = exp_full();
        chk(slice_full_o == ef, "R4", {req, " slice_full_o"}, 64'(slice_full_o), 64'(ef));
        chk(full_o == ef[N-1], "R4", {req, " full_o"}, 64'(full_o), 64'(ef[N-1]));
        for (int s = 0; s < N; s++) begin
            chk(pa_flat[s*PW +: PW] == m_pa[s], req, $sformatf("pa[%0d]", s),
                64'(pa_flat[s*PW +: PW]), 64'(m_pa[s]));
            chk(ds_flat[s*PW +: PW] == m_ds[s], req, $sformatf("ds[%0d]", s),
                64'(ds_flat[s*PW +: PW]), 64'(m_ds[s]));
        end
        for (int s = 0; s < N; s++) begin
            for (int e = 0; e < DEPTH; e++) begin
                rd_slice = SW'(s);
                rd_addr = AW'(e);
                #0.1ns;
                chk(rd_valid == m_valid[s][e], req, $sformatf("valid[%0d][%0d]", s, e),
                    64'(rd_valid), 64'(m_valid[s][e]));
                if (m_valid[s][e])
                    chk(rd_data == m_mem[s][e], req, $sformatf("data[%0d][%0d]", s, e),
                        64'(rd_data), 64'(m_mem[s][e]));
            end
        end
    endtask

    task automatic issue(input logic v, input logic [2:0] op, input logic [CW-1:0] d, input string req);
        cmd_valid = v;
        cmd_op = op;
        cmd_data = d;
        @(posedge clk);
        model_apply(v, op, d);
        @(negedge clk);
        cmd_valid = 1'b0;
        compare_all(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int pick;
        void'($urandom(32'd20241));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        compare_all("R1");

        // R6 R5 page-address loading through forced-full chain
        for (int s = 0; s < N; s++) begin
            issue(1'b1, 3'd3, CW'(16'h1000 + s), "R6");
            issue(1'b1, 3'd2, '0, "R5");
        end
        chk(full_o == 1'b1, "R5", "string forced full", 64'(full_o), 64'd1);
        // R9 page-address write on full string ignored
        issue(1'b1, 3'd3, 16'hDEAD, "R9");
        issue(1'b1, 3'd1, 16'hBEEF, "R9");
        // R7 control reset keeps page addresses
        issue(1'b1, 3'd5, '0, "R7");
        chk(pa_flat[PW-1:0] == 16'h1000, "R7", "pa[0] kept", 64'(pa_flat[PW-1:0]), 64'h1000);
        // R8 device select broadcast
        issue(1'b1, 3'd4, 16'hFFFF, "R8");
        // R10 idle and undefined opcodes
        issue(1'b0, 3'd1, 16'h1234, "R10");
        issue(1'b1, 3'd6, 16'h1234, "R10");
        issue(1'b1, 3'd0, 16'h1234, "R10");
        // R2 R3 fill the whole string in order
        for (int k = 0; k < N*DEPTH; k++) issue(1'b1, 3'd1, CW'(16'hA000 + k), "R2");
        chk(full_o == 1'b1, "R4", "filled string full", 64'(full_o), 64'd1);
        issue(1'b1, 3'd1, 16'h5555, "R9");
        issue(1'b1, 3'd2, 16'h0, "R9");
        issue(1'b1, 3'd5, '0, "R7");

        // R3 random mix
        for (int k = 0; k < 400; k++) begin
            logic [2:0] op;
            pick = $urandom_range(99);
            if (pick < 50) op = 3'd1;
            else if (pick < 60) op = 3'd2;
            else if (pick < 75) op = 3'd3;
            else if (pick < 85) op = 3'd4;
            else if (pick < 88) op = 3'd5;
            else op = 3'($urandom_range(7));
            issue(($urandom_range(9) != 0), op, CW'($urandom), "R3");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule